// File: doc/BRIEF.md
# Triggered Compare-and-Clear Unit

This unit watches a running pulse count and decides, at chosen moments, whether that count has reached a programmable threshold. When a compare moment arrives and the comparison holds, the unit raises a match strobe and a clear strobe together for one clock. The clear strobe goes to the counter, which sits outside this block.

A compare moment comes from one of two sources. The first is a tick of the sampling clock, divided by 1, 2, 4 or 8. The second is a rising edge on one channel of an eight-wide trigger bus. The selected channel can be inverted before edge detection, so a falling edge can serve as the trigger. The same selected and polarity-adjusted level can also gate counting, through a plain enable output.

The comparison has three forms: at-or-below the threshold, at-or-above it, or inside a window. In the window form the two bytes of the 16-bit threshold act as the window's bounds. The block carries no data stream, so it has no valid/ready handshake. Every pin is a level-sampled control or status signal, and the strobes are single-cycle pulses that cannot be held off.

Top module: `tcc_unit`

## Requirements
- R1: With `mode` = 0 (off) or 3 (reserved), `match_o` and `clear_o` stay low whatever the count, threshold and trigger bus do.
- R2: With `mode` = 1 (clock tick), a compare happens every 2^`div_sel` cycles. The divider restarts whenever `mode` is not 1, so the k-th cycle after `mode` becomes 1 is a compare cycle exactly when k is a multiple of 2^`div_sel` (div_sel 0, 1, 2, 3 give 1, 2, 4, 8). A hit on such a cycle shows on `match_o` one cycle after the inputs are applied.
- R3: With `mode` = 2 (trigger edge), a rising edge of the selected, polarity-adjusted trigger causes a compare. The trigger passes two sampling stages and one edge register, so a hit raises `match_o` in the third cycle after the bus changes. A trigger held high gives one pulse only.
- R4: `chan_sel` (3 bits) selects which bit of `trig_bus` is used. Edges on the other bits cause no strobe.
- R5: With `trig_pol` = 1 the selected bit is inverted before edge detection. A falling bus edge then triggers, and a rising bus edge does not.
- R6: `cmp_type` = 0 hits when `count` <= `top`.
- R7: `cmp_type` = 1 hits when `count` >= `top`.
- R8: `cmp_type` = 2 hits when `top[7:0]` <= `count` <= `top[15:8]`, both bounds taken as unsigned and inclusive.
- R9: `cmp_type` = 3 never hits.
- R10: `match_o` and `clear_o` are asserted together and only together. A compare moment without a hit produces neither strobe.
- R11: With `gate_en` = 0, `count_en_o` is 1. With `gate_en` = 1, `count_en_o` follows the selected, polarity-adjusted trigger level after the two sampling stages.
- R12: During and straight after reset, `match_o` and `clear_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count | input | 16 | Current pulse count |
| top | input | 16 | Threshold; its bytes are the window bounds in form 2 |
| trig_bus | input | 8 | External trigger channels |
| mode | input | 2 | 0 off, 1 clock tick, 2 trigger edge, 3 reserved (off) |
| div_sel | input | 2 | Tick divider exponent |
| cmp_type | input | 2 | 0 <=, 1 >=, 2 window, 3 never |
| trig_pol | input | 1 | Invert the selected trigger |
| chan_sel | input | 3 | Trigger channel index |
| gate_en | input | 1 | Let the trigger gate counting |
| match_o | output | 1 | Compare-hit strobe |
| clear_o | output | 1 | Counter clear strobe |
| count_en_o | output | 1 | Counting enable to the counter |

## Verification
A divider that fails to restart on mode entry shows up as match pulses at the wrong offset within the first eight cycles of tick mode. Each cadence is therefore checked cycle by cycle from the moment the mode is written. A stale edge register appears as a double pulse or a missing pulse within three cycles of a trigger change. A wrong comparator bound appears one cycle after the count crosses it, which is why each compare form is checked at its inclusive edges and one step beyond them.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [1:0] {
    TM_OFF  = 2'd0,
    TM_TICK = 2'd1,
    TM_EDGE = 2'd2,
    TM_RSVD = 2'd3
  } tcc_mode_e;

  typedef enum logic [1:0] {
    CMP_LE   = 2'd0,
    CMP_GE   = 2'd1,
    CMP_WIN  = 2'd2,
    CMP_NONE = 2'd3
  } tcc_cmp_e;
endpackage

// File: rtl/tcc_tick_gen.sv
// Divided tick: restarts at zero whenever run is low.
module tcc_tick_gen #(
  parameter int DIV_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 tick
);
  localparam int PC_W = (1 << DIV_SEL_W) - 1;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PC_W; i++) begin
      mask[i] = (i < int'(div_sel));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pc <= '0;
    else                pc <= pc + 1'b1;
  end

  assign tick = run && ((pc & mask) == mask);
endmodule

// File: rtl/tcc_trig_front.sv
// Sampling chain, channel pick, polarity, rising-edge detect and gate level.
module tcc_trig_front #(
  parameter int N_CHAN      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CHAN-1:0]         trig_bus,
  input  logic [$clog2(N_CHAN)-1:0] chan_sel,
  input  logic                      trig_pol,
  input  logic                      gate_en,
  output logic                      rise,
  output logic                      count_en
);
  logic [N_CHAN-1:0] stage [SYNC_STAGES];
  logic              lvl;
  logic              lvl_prev;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= trig_bus;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign lvl = stage[SYNC_STAGES-1][chan_sel] ^ trig_pol;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl;
  end

  assign rise     = lvl && !lvl_prev;
  assign count_en = !gate_en || lvl;
endmodule

// File: rtl/tcc_match_eval.sv
// Threshold comparator with the window form split across the threshold bytes.
module tcc_match_eval
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] top,
  input  logic [1:0]       cmp_type,
  output logic             hit
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] win_lo;
  logic [CNT_W-1:0] win_hi;

  assign win_lo = {{(CNT_W-HALF){1'b0}}, top[HALF-1:0]};
  assign win_hi = {{HALF{1'b0}}, top[CNT_W-1:HALF]};

  always_comb begin
    unique case (tcc_cmp_e'(cmp_type))
      CMP_LE:  hit = (count <= top);
      CMP_GE:  hit = (count >= top);
      CMP_WIN: hit = (count >= win_lo) && (count <= win_hi);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int N_CHAN      = 8,
  parameter int DIV_SEL_W   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(N_CHAN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     count,
  input  logic [CNT_W-1:0]     top,
  input  logic [N_CHAN-1:0]    trig_bus,
  input  logic [1:0]           mode,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic [1:0]           cmp_type,
  input  logic                 trig_pol,
  input  logic [SEL_W-1:0]     chan_sel,
  input  logic                 gate_en,
  output logic                 match_o,
  output logic                 clear_o,
  output logic                 count_en_o
);
  logic tick;
  logic rise;
  logic hit;
  logic event_now;
  logic strobe_q;

  tcc_tick_gen #(.DIV_SEL_W(DIV_SEL_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tcc_mode_e'(mode) == TM_TICK),
    .div_sel (div_sel),
    .tick    (tick)
  );

  tcc_trig_front #(.N_CHAN(N_CHAN), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_bus (trig_bus),
    .chan_sel (chan_sel),
    .trig_pol (trig_pol),
    .gate_en  (gate_en),
    .rise     (rise),
    .count_en (count_en_o)
  );

  tcc_match_eval #(.CNT_W(CNT_W)) u_eval (
    .count    (count),
    .top      (top),
    .cmp_type (cmp_type),
    .hit      (hit)
  );

  always_comb begin
    unique case (tcc_mode_e'(mode))
      TM_TICK: event_now = tick;
      TM_EDGE: event_now = rise;
      default: event_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= event_now && hit;
  end

  assign match_o = strobe_q;
  assign clear_o = strobe_q;
endmodule

// File: rtl/tcc_unit_chk.sv
module tcc_unit_chk #(
  parameter int CNT_W     = 16,
  parameter int N_CHAN    = 8,
  parameter int DIV_SEL_W = 2,
  parameter int SEL_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CNT_W-1:0]     count,
  input logic [CNT_W-1:0]     top,
  input logic [1:0]           mode,
  input logic [DIV_SEL_W-1:0] div_sel,
  input logic [1:0]           cmp_type,
  input logic                 match_o
);
  localparam int HALF = CNT_W / 2;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 || mode == 2'd3) |=> !match_o); // R1
  AST_DIV2_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && div_sel == DIV_SEL_W'(1) && $past(mode) == 2'd1
     && $past(div_sel) == DIV_SEL_W'(1) && match_o) |=> !match_o); // R2
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && match_o) |=> !match_o); // R3
  AST_LE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_type == 2'd0 && count > top) |=> !match_o); // R6
  AST_GE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_type == 2'd1 && count < top) |=> !match_o); // R7
  AST_WIN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_type == 2'd2 && (count > CNT_W'(top[CNT_W-1:HALF])
                          || count < CNT_W'(top[HALF-1:0]))) |=> !match_o); // R8
  AST_NEVER_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_type == 2'd3) |=> !match_o); // R9
endmodule

bind tcc_unit tcc_unit_chk #(
  .CNT_W(CNT_W), .N_CHAN(N_CHAN), .DIV_SEL_W(DIV_SEL_W), .SEL_W(SEL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .count    (count),
  .top      (top),
  .mode     (mode),
  .div_sel  (div_sel),
  .cmp_type (cmp_type),
  .match_o  (match_o)
);

// File: tb/tcc_unit_tb.sv
module tcc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] count, top;
  logic [7:0]  trig_bus;
  logic [1:0]  mode, div_sel, cmp_type;
  logic        trig_pol, gate_en;
  logic [2:0]  chan_sel;
  logic        match_o, clear_o, count_en_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tcc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .count(count), .top(top), .trig_bus(trig_bus),
    .mode(mode), .div_sel(div_sel), .cmp_type(cmp_type), .trig_pol(trig_pol),
    .chan_sel(chan_sel), .gate_en(gate_en),
    .match_o(match_o), .clear_o(clear_o), .count_en_o(count_en_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Check both strobes against one expectation (R10 pairing).
  task automatic chk_strobe(input logic exp, input string req);
    chk(match_o, exp, req);
    chk(clear_o, exp, {req, "/R10"});
  endtask

  task automatic idle();
    mode = 2'd0; trig_bus = '0; trig_pol = 1'b0; gate_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; count = '0; top = '0; trig_bus = '0; mode = 2'd0;
    div_sel = '0; cmp_type = 2'd0; trig_pol = 1'b0; chan_sel = '0; gate_en = 1'b0;
    repeat (3) @(negedge clk);
    chk_strobe(1'b0, "R12 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_strobe(1'b0, "R12 after reset");
  endtask

  task automatic t_cadence(input logic [1:0] d);
    int n;
    idle();
    n = 1 << d;
    count = 16'd3; top = 16'd9; cmp_type = 2'd0; div_sel = d;
    mode = 2'd1;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      chk_strobe((k % n) == 0, $sformatf("R2 div%0d k=%0d", n, k));
    end
    mode = 2'd0;
  endtask

  task automatic t_compare();
    idle();
    div_sel = 2'd0; mode = 2'd1;
    cmp_type = 2'd0;
    top = 16'd100; count = 16'd100; @(negedge clk); chk_strobe(1'b1, "R6 equal");
    count = 16'd101; @(negedge clk); chk_strobe(1'b0, "R6 above");
    count = 16'd0;   @(negedge clk); chk_strobe(1'b1, "R6 zero");
    cmp_type = 2'd1;
    count = 16'd100; @(negedge clk); chk_strobe(1'b1, "R7 equal");
    count = 16'd99;  @(negedge clk); chk_strobe(1'b0, "R7 below");
    count = 16'hFFFF; @(negedge clk); chk_strobe(1'b1, "R7 max");
    cmp_type = 2'd2; top = 16'h3010;
    count = 16'h0010; @(negedge clk); chk(match_o, 1'b1, "R8 low bound");
    count = 16'h0030; @(negedge clk); chk(match_o, 1'b1, "R8 high bound");
    count = 16'h000F; @(negedge clk); chk(match_o, 1'b0, "R8 below");
    count = 16'h0031; @(negedge clk); chk(match_o, 1'b0, "R8 above");
    count = 16'h1020; @(negedge clk); chk(match_o, 1'b0, "R8 wide count");
    cmp_type = 2'd3; top = 16'h8000;
    count = 16'h8000; @(negedge clk); chk(match_o, 1'b0, "R9 equal");
    count = 16'h0000; @(negedge clk); chk(match_o, 1'b0, "R9 zero");
    mode = 2'd0;
  endtask

  task automatic t_off();
    idle();
    count = 16'd1; top = 16'd5; cmp_type = 2'd0; chan_sel = 3'd1;
    for (int m = 0; m < 4; m += 3) begin
      mode = 2'(m);
      for (int k = 0; k < 6; k++) begin
        trig_bus = (k % 2 == 0) ? 8'hFF : 8'h00;
        @(negedge clk);
        chk_strobe(1'b0, $sformatf("R1 mode%0d", m));
      end
    end
    idle();
  endtask

  task automatic t_edge();
    idle();
    chan_sel = 3'd4; count = 16'd5; top = 16'd10; cmp_type = 2'd0;
    mode = 2'd2; @(negedge clk);
    trig_bus[4] = 1'b1;
    @(negedge clk); chk_strobe(1'b0, "R3 lat1");
    @(negedge clk); chk_strobe(1'b0, "R3 lat2");
    @(negedge clk); chk_strobe(1'b1, "R3 lat3");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk_strobe(1'b0, "R3 held high");
    end
    trig_bus[4] = 1'b0; repeat (3) @(negedge clk);
    count = 16'd11; trig_bus[4] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); chk_strobe(1'b0, "R10 edge without hit");
    end
    count = 16'd5; trig_bus = 8'hEF;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); chk(match_o, 1'b0, "R4 other channels");
    end
    trig_bus = 8'hEF; trig_bus[4] = 1'b0; @(negedge clk);
    trig_bus = 8'h00; repeat (3) @(negedge clk);
    trig_bus[4] = 1'b1;
    repeat (3) @(negedge clk); chk(match_o, 1'b1, "R4 selected channel");
    idle();
  endtask

  task automatic t_pol();
    idle();
    chan_sel = 3'd6; trig_pol = 1'b1; count = 16'd2; top = 16'd2; cmp_type = 2'd1;
    repeat (4) @(negedge clk);
    mode = 2'd2;
    trig_bus[6] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); chk(match_o, 1'b0, "R5 rising ignored");
    end
    trig_bus[6] = 1'b0;
    repeat (2) @(negedge clk); chk(match_o, 1'b0, "R5 lat2");
    @(negedge clk); chk(match_o, 1'b1, "R5 falling triggers");
    idle();
  endtask

  task automatic t_gate();
    idle();
    chk(count_en_o, 1'b1, "R11 gate off");
    chan_sel = 3'd2; gate_en = 1'b1; trig_bus = 8'hFB;
    repeat (3) @(negedge clk); chk(count_en_o, 1'b0, "R11 gated low");
    trig_bus[2] = 1'b1;
    @(negedge clk); chk(count_en_o, 1'b0, "R11 stage delay");
    repeat (2) @(negedge clk); chk(count_en_o, 1'b1, "R11 gated high");
    trig_pol = 1'b1; @(negedge clk); chk(count_en_o, 1'b0, "R11 inverted");
    gate_en = 1'b0; @(negedge clk); chk(count_en_o, 1'b1, "R11 gate dropped");
    idle();
  endtask

  initial begin
    fork
      begin
        t_reset();
        for (int d = 0; d < 4; d++) t_cadence(2'(d));
        t_compare();
        t_off();
        t_edge();
        t_pol();
        t_gate();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule